// File: doc/BRIEF.md
# Multi-Bank Flash Command Sequencer

This block is the command front end of a four-bank parallel NOR-style flash. It watches a parallel bus with chip enable, write enable and output enable strobes. It turns qualified write cycles into command sequences: word program, sector erase (one or more sectors), chip erase, unlock-bypass entry and exit, identification mode, erase suspend and resume, and reset. A decode state machine tracks how far a sequence has progressed. A separate operation engine runs a started program or erase for a number of clock cycles set by parameters. When an operation finishes, the engine updates a behavioural memory through a simple strobe port.

Reads go to the array with no added latency unless the addressed bank is busy. A read from a busy bank returns a status word with a toggling bit. A read from the sector being erased also returns that status word while the erase is suspended. In identification mode, reads return the identification word instead of array data. Sectors listed in a protection parameter reject program and erase as timed no-ops. While the accelerate input is high, protection is lifted and the short two-write program form is accepted.

Sequence states: S_READ (read array), S_UNL1 (first unlock seen), S_UNL2 (second unlock seen), S_PROG_DATA (waiting for the program word), S_ERS0/S_ERS1/S_ERS2 (second unlock pair after the erase setup), S_AUTOSEL (identification reads), S_BYP_EXIT (bypass exit armed). The sequence normally falls back to S_READ on any write that does not fit.

Engine states: E_IDLE, E_PROG, E_WIN (collecting sectors), E_ERASE, E_SUSP, E_SPROG (a program while the erase is suspended). The engine moves IDLE→PROG→IDLE, IDLE→WIN→ERASE→IDLE, IDLE→ERASE for a chip erase, ERASE→SUSP→ERASE for suspend and resume, and SUSP→SPROG→SUSP.

Top module: `flash_cmd_seq`

## Requirements
- R1: A clock cycle counts as a command write only when ce_n=0, we_n=0 and oe_n=1. A cycle with oe_n=0 changes no sequence state and starts no operation.
- R2: The four-write program (0xAA at word 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the data word at its address) keeps the target bank busy for exactly PROG_CYC cycles. It then writes that word to that address in the array.
- R3: 0xAA@0x555, 0x55@0x2AA, 0x20@0x555 enters bypass mode. In bypass mode, 0xA0 at any address followed by the data write programs. 0x90 followed by 0x00 leaves bypass mode, after which a bare 0xA0 no longer starts a program.
- R4: While accel=1 the two-write bypass program is accepted without bypass entry. A protected sector is then programmed normally, taking PROG_CYC busy cycles.
- R5: With accel=0, a program to a protected sector (PROT_MASK bit set; the sector is the top SEC_BITS address bits) keeps the bank busy for NOP_CYC cycles and writes nothing.
- R6: A read (ce_n=0, oe_n=0, we_n=1) from a bank that is not busy returns the array word in the same cycle, even while another bank is busy.
- R7: A read from a busy bank returns a status word in which only bit 6 may be set, and bit 6 inverts on every such read.
- R8: A sector erase (0xAA,0x55,0x80,0xAA,0x55, then 0x30 at the sector address) collects further 0x30 sector writes issued within WIN_CYC cycles of the last one. It then erases all collected unprotected sectors with one strobe whose mask has bit s set for sector s.
- R9: A chip erase (second unlock pair, then 0x10 at 0x555) erases every sector whose PROT_MASK bit is clear.
- R10: 0xB0 during an erase suspends it. Bank flags then drop. Reads of the erasing sector give status; other sectors read from the array. A program outside the erasing sectors runs, while one inside them is dropped. 0x30 resumes the erase.
- R11: 0xAA,0x55,0x90 enters identification mode. Reads then return MFG_ID at word offset 0, DEV_ID at offset 1, and the sector's protection bit at offset 2. Any write, such as 0xF0, returns to array reads.
- R12: A write that does not fit the expected sequence returns to array reads and starts no operation.
- R13: bank_busy bit b is set exactly while bank b (the top BANK_BITS address bits) is programming, collecting sectors or erasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data |
| accel | input | 1 | Accelerate: forced bypass, protection lifted |
| dq_out | output | 16 | Read data (array, status or identification) |
| dq_oe | output | 1 | High during a read cycle |
| bank_busy | output | 4 | Per-bank busy flags |
| arr_rd_addr | output | ADDR_W | Array read address |
| arr_rd_data | input | 16 | Array read data, combinational |
| arr_wr | output | 1 | Program strobe, one cycle |
| arr_wr_addr | output | ADDR_W | Program address |
| arr_wr_data | output | 16 | Program data |
| arr_erase | output | 1 | Erase strobe, one cycle |
| arr_erase_mask | output | 16 | Sectors to erase with the strobe |

## Verification
The assertions assume that every bus cycle is a read, a write or idle. They also assume that ce_n, we_n and oe_n change only between clock edges, so that a write or read is seen on exactly one edge. The bench drives every strobe from the falling edge and holds it for one cycle. It never combines we_n=0 with oe_n=0, except in the deliberate R1 case. The assertions also take for granted that no new sequence arrives while an operation owns the engine. The bench waits for bank_busy to clear before each new sequence, except for the suspend and extra-sector writes that the requirements allow.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        S_READ, S_UNL1, S_UNL2, S_PROG_DATA,
        S_ERS0, S_ERS1, S_ERS2, S_AUTOSEL, S_BYP_EXIT
    } seq_st_t;

    typedef enum logic [2:0] {
        E_IDLE, E_PROG, E_WIN, E_ERASE, E_SUSP, E_SPROG
    } eng_st_t;

    localparam logic [10:0] UNL_ADDR_A = 11'h555;
    localparam logic [10:0] UNL_ADDR_B = 11'h2AA;

    localparam logic [7:0] K_UNL_A  = 8'hAA;
    localparam logic [7:0] K_UNL_B  = 8'h55;
    localparam logic [7:0] K_PROG   = 8'hA0;
    localparam logic [7:0] K_ERS    = 8'h80;
    localparam logic [7:0] K_IDENT  = 8'h90;
    localparam logic [7:0] K_BYPASS = 8'h20;
    localparam logic [7:0] K_CHIP   = 8'h10;
    localparam logic [7:0] K_SECT   = 8'h30;
    localparam logic [7:0] K_SUSP   = 8'hB0;
    localparam logic [7:0] K_BEXIT  = 8'h00;

    localparam int STAT_TGL_BIT = 6;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_cyc,
    input  logic [10:0] addr_lo,
    input  logic [7:0]  data_lo,
    input  logic        accel,
    input  logic        eng_ready,
    input  logic        eng_susp,
    output logic        cmd_prog,
    output logic        cmd_chip,
    output logic        cmd_sec,
    output logic        cmd_susp,
    output logic        cmd_30,
    output logic        ident_mode
);

    seq_st_t st, st_nx;
    logic    byp_q, byp_nx;
    logic    at_a, at_b, byp_eff;

    assign at_a    = (addr_lo == UNL_ADDR_A);
    assign at_b    = (addr_lo == UNL_ADDR_B);
    assign byp_eff = byp_q | accel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_READ;
            byp_q <= 1'b0;
        end else begin
            st    <= st_nx;
            byp_q <= byp_nx;
        end
    end

    always_comb begin
        st_nx    = st;
        byp_nx   = byp_q;
        cmd_prog = 1'b0;
        cmd_chip = 1'b0;
        cmd_sec  = 1'b0;
        cmd_susp = 1'b0;
        cmd_30   = 1'b0;
        if (wr_cyc) begin
            unique case (st)
                S_READ: begin
                    if (data_lo == K_SUSP) begin
                        cmd_susp = 1'b1;
                    end else if (data_lo == K_SECT) begin
                        cmd_30 = 1'b1;
                    end else if (eng_ready) begin
                        if (byp_eff) begin
                            if (data_lo == K_PROG)       st_nx = S_PROG_DATA;
                            else if (data_lo == K_IDENT) st_nx = S_BYP_EXIT;
                        end else if (data_lo == K_UNL_A && at_a) begin
                            st_nx = S_UNL1;
                        end
                    end
                end
                S_UNL1: st_nx = (data_lo == K_UNL_B && at_b) ? S_UNL2 : S_READ;
                S_UNL2: begin
                    st_nx = S_READ;
                    if (at_a) begin
                        if (data_lo == K_PROG)                    st_nx = S_PROG_DATA;
                        else if (data_lo == K_ERS && !eng_susp)   st_nx = S_ERS0;
                        else if (data_lo == K_IDENT)              st_nx = S_AUTOSEL;
                        else if (data_lo == K_BYPASS)             byp_nx = 1'b1;
                    end
                end
                S_PROG_DATA: begin
                    cmd_prog = 1'b1;
                    st_nx    = S_READ;
                end
                S_ERS0: st_nx = (data_lo == K_UNL_A && at_a) ? S_ERS1 : S_READ;
                S_ERS1: st_nx = (data_lo == K_UNL_B && at_b) ? S_ERS2 : S_READ;
                S_ERS2: begin
                    st_nx = S_READ;
                    if (data_lo == K_CHIP && at_a) cmd_chip = 1'b1;
                    else if (data_lo == K_SECT)    cmd_sec  = 1'b1;
                end
                S_AUTOSEL: st_nx = S_READ;
                S_BYP_EXIT: begin
                    st_nx = S_READ;
                    if (data_lo == K_BEXIT) byp_nx = 1'b0;
                end
                default: st_nx = S_READ;
            endcase
        end
    end

    assign ident_mode = (st == S_AUTOSEL);

    // R1: nothing moves without a qualified write
    p_hold_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cyc |=> ($stable(st) && $stable(byp_q)));

    // R3: 0x90 then 0x00 leaves bypass
    p_bypass_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BYP_EXIT && wr_cyc && data_lo == K_BEXIT) |=> !byp_q);

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SEC_BITS  = 4,
    parameter int BANK_BITS = 2,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 60,
    parameter int NOP_CYC   = 4,
    parameter int WIN_CYC   = 16,
    parameter logic [(1<<SEC_BITS)-1:0] PROT_MASK = 16'h8100,
    localparam int NSEC  = 1 << SEC_BITS,
    localparam int NBANK = 1 << BANK_BITS
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       data,
    input  logic              cmd_prog,
    input  logic              cmd_chip,
    input  logic              cmd_sec,
    input  logic              cmd_susp,
    input  logic              cmd_30,
    output logic              eng_ready,
    output logic              eng_susp,
    output logic [NBANK-1:0]  bank_busy,
    output logic [NSEC-1:0]   susp_mask,
    output logic              arr_wr,
    output logic [ADDR_W-1:0] arr_wr_addr,
    output logic [15:0]       arr_wr_data,
    output logic              arr_erase,
    output logic [NSEC-1:0]   arr_erase_mask
);

    localparam int SPB   = NSEC / NBANK;
    localparam int MAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_B = (NOP_CYC > WIN_CYC) ? NOP_CYC : WIN_CYC;
    localparam int CNT_W = $clog2(((MAX_A > MAX_B) ? MAX_A : MAX_B) + 1);
    localparam logic [CNT_W-1:0] L_PROG = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] L_ERS  = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] L_NOP  = CNT_W'(NOP_CYC - 1);
    localparam logic [CNT_W-1:0] L_WIN  = CNT_W'(WIN_CYC - 1);

    eng_st_t st, st_nx;
    logic [CNT_W-1:0]     pcnt, ecnt, wcnt;
    logic [ADDR_W-1:0]    p_addr;
    logic [15:0]          p_data;
    logic                 p_prot;
    logic [NSEC-1:0]      req_mask, eff_mask, prot_eff, win_eff;
    logic [SEC_BITS-1:0]  a_sec;
    logic [BANK_BITS-1:0] p_bank;
    logic                 prog_ok_susp;

    assign a_sec        = addr[ADDR_W-1 -: SEC_BITS];
    assign p_bank       = p_addr[ADDR_W-1 -: BANK_BITS];
    assign prot_eff     = PROT_MASK & {NSEC{~accel}};
    assign win_eff      = req_mask & ~prot_eff;
    assign prog_ok_susp = cmd_prog && !req_mask[a_sec];

    always_ff @(posedge clk) begin
        if (!rst_n) st <= E_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            E_IDLE: begin
                if (cmd_prog)      st_nx = E_PROG;
                else if (cmd_chip) st_nx = E_ERASE;
                else if (cmd_sec)  st_nx = E_WIN;
            end
            E_PROG:  if (pcnt == '0) st_nx = E_IDLE;
            E_WIN:   if (!cmd_30 && wcnt == '0) st_nx = E_ERASE;
            E_ERASE: begin
                if (cmd_susp)          st_nx = E_SUSP;
                else if (ecnt == '0)   st_nx = E_IDLE;
            end
            E_SUSP: begin
                if (cmd_30)            st_nx = E_ERASE;
                else if (prog_ok_susp) st_nx = E_SPROG;
            end
            E_SPROG: if (pcnt == '0) st_nx = E_SUSP;
            default: st_nx = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0; ecnt <= '0; wcnt <= '0;
            p_addr <= '0; p_data <= '0; p_prot <= 1'b0;
            req_mask <= '0; eff_mask <= '0;
            arr_wr <= 1'b0; arr_wr_addr <= '0; arr_wr_data <= '0;
            arr_erase <= 1'b0; arr_erase_mask <= '0;
        end else begin
            arr_wr    <= 1'b0;
            arr_erase <= 1'b0;
            unique case (st)
                E_IDLE: begin
                    if (cmd_prog) begin
                        p_addr <= addr;
                        p_data <= data;
                        p_prot <= prot_eff[a_sec];
                        pcnt   <= prot_eff[a_sec] ? L_NOP : L_PROG;
                    end else if (cmd_chip) begin
                        req_mask <= '1;
                        eff_mask <= ~prot_eff;
                        ecnt     <= (~prot_eff == '0) ? L_NOP : L_ERS;
                    end else if (cmd_sec) begin
                        req_mask <= NSEC'(1) << a_sec;
                        wcnt     <= L_WIN;
                    end
                end
                E_PROG, E_SPROG: begin
                    if (pcnt == '0) begin
                        arr_wr      <= !p_prot;
                        arr_wr_addr <= p_addr;
                        arr_wr_data <= p_data;
                    end else begin
                        pcnt <= pcnt - 1'b1;
                    end
                end
                E_WIN: begin
                    if (cmd_30) begin
                        req_mask[a_sec] <= 1'b1;
                        wcnt            <= L_WIN;
                    end else if (wcnt == '0) begin
                        eff_mask <= win_eff;
                        ecnt     <= (win_eff == '0) ? L_NOP : L_ERS;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                E_ERASE: begin
                    if (!cmd_susp) begin
                        if (ecnt == '0) begin
                            arr_erase      <= (eff_mask != '0);
                            arr_erase_mask <= eff_mask;
                            req_mask       <= '0;
                        end else begin
                            ecnt <= ecnt - 1'b1;
                        end
                    end
                end
                E_SUSP: begin
                    if (!cmd_30 && prog_ok_susp) begin
                        p_addr <= addr;
                        p_data <= data;
                        p_prot <= prot_eff[a_sec];
                        pcnt   <= prot_eff[a_sec] ? L_NOP : L_PROG;
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_busy
        assign bank_busy[b] =
            ((st == E_PROG || st == E_SPROG) && p_bank == BANK_BITS'(b)) ||
            ((st == E_WIN || st == E_ERASE) && (|req_mask[b*SPB +: SPB]));
    end

    assign susp_mask = (st == E_SUSP || st == E_SPROG) ? req_mask : '0;
    assign eng_ready = (st == E_IDLE) || (st == E_SUSP);
    assign eng_susp  = (st == E_SUSP);

    // R2: a program strobe only follows a running program
    p_wr_after_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr |-> ($past(st) == E_PROG || $past(st) == E_SPROG));

    // R8: an erase strobe always names at least one sector
    p_erase_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_erase |-> (arr_erase_mask != '0));

    // R10: a suspended erase leaves every bank flag clear
    p_susp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_SUSP) |-> (bank_busy == '0));

    // R13: a plain program occupies exactly one bank
    p_prog_one_bank_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_PROG) |-> ($countones(bank_busy) == 1));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SEC_BITS  = 4,
    parameter int BANK_BITS = 2,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 60,
    parameter int NOP_CYC   = 4,
    parameter int WIN_CYC   = 16,
    parameter logic [(1<<SEC_BITS)-1:0] PROT_MASK = 16'h8100,
    parameter logic [15:0] MFG_ID = 16'h00C1,
    parameter logic [15:0] DEV_ID = 16'h227E,
    localparam int NSEC  = 1 << SEC_BITS,
    localparam int NBANK = 1 << BANK_BITS
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    input  logic              accel,
    output logic [15:0]       dq_out,
    output logic              dq_oe,
    output logic [NBANK-1:0]  bank_busy,
    output logic [ADDR_W-1:0] arr_rd_addr,
    input  logic [15:0]       arr_rd_data,
    output logic              arr_wr,
    output logic [ADDR_W-1:0] arr_wr_addr,
    output logic [15:0]       arr_wr_data,
    output logic              arr_erase,
    output logic [NSEC-1:0]   arr_erase_mask
);

    logic wr_cyc, rd_cyc;
    logic cmd_prog, cmd_chip, cmd_sec, cmd_susp, cmd_30;
    logic eng_ready, eng_susp, ident_mode;
    logic [NSEC-1:0]      susp_mask;
    logic [SEC_BITS-1:0]  r_sec;
    logic [BANK_BITS-1:0] r_bank;
    logic status_hit, tgl;
    logic [15:0] id_word;

    assign wr_cyc = !ce_n && !we_n && oe_n;
    assign rd_cyc = !ce_n && !oe_n && we_n;
    assign r_sec  = addr[ADDR_W-1 -: SEC_BITS];
    assign r_bank = addr[ADDR_W-1 -: BANK_BITS];

    flash_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .wr_cyc(wr_cyc),
        .addr_lo(addr[10:0]), .data_lo(dq_in[7:0]), .accel(accel),
        .eng_ready(eng_ready), .eng_susp(eng_susp),
        .cmd_prog(cmd_prog), .cmd_chip(cmd_chip), .cmd_sec(cmd_sec),
        .cmd_susp(cmd_susp), .cmd_30(cmd_30), .ident_mode(ident_mode)
    );

    flash_op_engine #(
        .ADDR_W(ADDR_W), .SEC_BITS(SEC_BITS), .BANK_BITS(BANK_BITS),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .NOP_CYC(NOP_CYC),
        .WIN_CYC(WIN_CYC), .PROT_MASK(PROT_MASK)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .accel(accel), .addr(addr), .data(dq_in),
        .cmd_prog(cmd_prog), .cmd_chip(cmd_chip), .cmd_sec(cmd_sec),
        .cmd_susp(cmd_susp), .cmd_30(cmd_30),
        .eng_ready(eng_ready), .eng_susp(eng_susp),
        .bank_busy(bank_busy), .susp_mask(susp_mask),
        .arr_wr(arr_wr), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
        .arr_erase(arr_erase), .arr_erase_mask(arr_erase_mask)
    );

    assign status_hit = bank_busy[r_bank] || susp_mask[r_sec];

    always_ff @(posedge clk) begin
        if (!rst_n)                   tgl <= 1'b0;
        else if (rd_cyc && status_hit) tgl <= ~tgl;
    end

    always_comb begin
        unique case (addr[1:0])
            2'd0:    id_word = MFG_ID;
            2'd1:    id_word = DEV_ID;
            2'd2:    id_word = {15'd0, PROT_MASK[r_sec]};
            default: id_word = 16'd0;
        endcase
    end

    always_comb begin
        dq_out = '0;
        if (rd_cyc) begin
            if (status_hit)      dq_out[STAT_TGL_BIT] = tgl;
            else if (ident_mode) dq_out = id_word;
            else                 dq_out = arr_rd_data;
        end
    end

    assign dq_oe       = rd_cyc;
    assign arr_rd_addr = addr;

    // R7: busy reads carry nothing but the toggle bit
    p_status_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && status_hit) |-> ((dq_out & ~(16'h1 << STAT_TGL_BIT)) == 16'h0));

endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;

    localparam int PROG = 12, ERS = 40, NOP = 3, WIN = 8;
    localparam logic [15:0] PROT = 16'h8100;

    logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1, accel = 0;
    logic [11:0] addr = '0;
    logic [15:0] dq_in = '0, dq_out, arr_rd_data, arr_wr_data, arr_erase_mask;
    logic [11:0] arr_rd_addr, arr_wr_addr;
    logic dq_oe, arr_wr, arr_erase;
    logic [3:0] bank_busy;

    logic [15:0] mem [0:4095];
    logic [15:0] exp_mem [0:4095];
    int n_chk = 0, n_bad = 0, wr_seen = 0, er_seen = 0, cyc = 0;
    logic [15:0] er_mask = '0;

    always #10 clk = ~clk;

    flash_cmd_seq #(.PROG_CYC(PROG), .ERASE_CYC(ERS), .NOP_CYC(NOP), .WIN_CYC(WIN),
                    .PROT_MASK(PROT)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .accel(accel), .dq_out(dq_out), .dq_oe(dq_oe),
        .bank_busy(bank_busy), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
        .arr_wr(arr_wr), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
        .arr_erase(arr_erase), .arr_erase_mask(arr_erase_mask));

    assign arr_rd_data = mem[arr_rd_addr];

    always @(posedge clk) begin
        if (arr_wr) begin mem[arr_wr_addr] = arr_wr_data; wr_seen++; end
        if (arr_erase) begin
            er_seen++; er_mask = arr_erase_mask;
            for (int i = 0; i < 4096; i++) if (arr_erase_mask[i >> 8]) mem[i] = 16'hFFFF;
        end
    end

    function automatic logic [15:0] init_word(input int a);
        return 16'(a) ^ 16'h5A5A;
    endfunction

    function automatic logic [3:0] bank_bit(input logic [11:0] a);
        return 4'b0001 << a[11:10];
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            summary();
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = a; dq_in = d;
        @(negedge clk); ce_n = 1; we_n = 1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] q);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        #2 q = dq_out;
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (bank_busy != 0 && n < 2000) begin n++; @(negedge clk); end
        @(negedge clk);
    endtask

    task automatic std_prog(input logic [11:0] a, input logic [15:0] d);
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0); wr(a, d);
    endtask

    task automatic ers_pre();
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0080);
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055);
    endtask

    task automatic apply_erase(input logic [15:0] m);
        for (int i = 0; i < 4096; i++) if (m[i >> 8]) exp_mem[i] = 16'hFFFF;
    endtask

    initial begin
        logic [15:0] q, q2;
        int n, w0, sd;
        for (int i = 0; i < 4096; i++) begin mem[i] = init_word(i); exp_mem[i] = init_word(i); end
        sd = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R13 reset busy", {12'd0, bank_busy}, 16'h0000);
        rd(12'h123, q); check("R6 reset read", q, exp_mem[12'h123]);

        // R2: standard program, exact duration
        std_prog(12'h130, 16'h1357);
        check("R13 busy bank0", {12'd0, bank_busy}, 16'h0001);
        wait_idle(n); check("R2 duration", 16'(n), 16'(PROG));
        exp_mem[12'h130] = 16'h1357;
        rd(12'h130, q); check("R2 data", q, 16'h1357);

        // R7 status toggle and R6 read of another bank while busy
        std_prog(12'h140, 16'h2468);
        rd(12'h150, q); rd(12'h150, q2);
        check("R7 toggle", q ^ q2, 16'h0040);
        check("R7 other bits", q & 16'hFFBF, 16'h0000);
        rd(12'hA40, q); check("R6 other bank", q, exp_mem[12'hA40]);
        wait_idle(n); exp_mem[12'h140] = 16'h2468;
        rd(12'h140, q); check("R2 second data", q, 16'h2468);

        // R1: oe low during write sequence has no effect
        w0 = wr_seen;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0;
            addr = (k == 0 || k == 2) ? 12'h555 : (k == 1 ? 12'h2AA : 12'h160);
            dq_in = (k == 0) ? 16'hAA : (k == 1) ? 16'h55 : (k == 2) ? 16'hA0 : 16'h0000;
            @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
        end
        @(negedge clk);
        check("R1 no busy", {12'd0, bank_busy}, 16'h0000);
        check("R1 no write", 16'(wr_seen - w0), 16'h0000);

        // R5 protected program is a timed no-op
        w0 = wr_seen;
        std_prog(12'h820, 16'h0000);
        wait_idle(n); check("R5 nop duration", 16'(n), 16'(NOP));
        check("R5 no write", 16'(wr_seen - w0), 16'h0000);
        rd(12'h820, q); check("R5 data kept", q, exp_mem[12'h820]);

        // R4 accel: two-write program into protected sector
        accel = 1;
        wr(12'h000, 16'h00A0); wr(12'hF10, 16'hC0DE);
        wait_idle(n); check("R4 duration", 16'(n), 16'(PROG));
        exp_mem[12'hF10] = 16'hC0DE;
        accel = 0;
        rd(12'hF10, q); check("R4 data", q, 16'hC0DE);

        // R3 bypass entry, short program, exit
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0020);
        wr(12'h7FF, 16'h00A0); wr(12'h444, 16'hBEEF);
        wait_idle(n); check("R3 bypass duration", 16'(n), 16'(PROG));
        exp_mem[12'h444] = 16'hBEEF;
        rd(12'h444, q); check("R3 bypass data", q, 16'hBEEF);
        wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);
        w0 = wr_seen;
        wr(12'h000, 16'h00A0); wr(12'h446, 16'h1111);
        check("R3 exit no busy", {12'd0, bank_busy}, 16'h0000);
        @(negedge clk); check("R3 exit no write", 16'(wr_seen - w0), 16'h0000);

        // R11 identification mode
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0090);
        rd(12'h000, q); check("R11 mfg", q, 16'h00C1);
        rd(12'h001, q); check("R11 dev", q, 16'h227E);
        rd(12'hF02, q); check("R11 prot set", q, 16'h0001);
        rd(12'h102, q); check("R11 prot clear", q, 16'h0000);
        wr(12'h000, 16'h00F0);
        rd(12'h000, q); check("R11 exit", q, exp_mem[12'h000]);

        // R12 broken sequence
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h554, 16'h0090);
        rd(12'h001, q); check("R12 array after break", q, exp_mem[12'h001]);
        w0 = wr_seen;
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0077); wr(12'h170, 16'h0);
        @(negedge clk);
        check("R12 no busy", {12'd0, bank_busy}, 16'h0000);
        check("R12 no write", 16'(wr_seen - w0), 16'h0000);

        // R8 multi-sector erase inside window
        ers_pre(); wr(12'h300, 16'h0030); wr(12'h400, 16'h0030);
        check("R13 erase banks", {12'd0, bank_busy}, 16'h0003);
        rd(12'h900, q); check("R6 read during erase", q, exp_mem[12'h900]);
        w0 = er_seen;
        wait_idle(n);
        check("R8 one strobe", 16'(er_seen - w0), 16'h0001);
        check("R8 mask", er_mask, 16'h0018);
        apply_erase(16'h0018);
        rd(12'h3A0, q); check("R8 erased", q, 16'hFFFF);
        rd(12'h5A0, q); check("R8 neighbour kept", q, exp_mem[12'h5A0]);

        // R10 suspend / resume
        ers_pre(); wr(12'h600, 16'h0030);
        repeat (WIN + 6) @(negedge clk);
        wr(12'h000, 16'h00B0);
        check("R10 busy clear", {12'd0, bank_busy}, 16'h0000);
        rd(12'h610, q); rd(12'h610, q2);
        check("R10 erasing sector status", q ^ q2, 16'h0040);
        rd(12'h510, q); check("R10 same bank array", q, exp_mem[12'h510]);
        std_prog(12'h720, 16'hABCD);
        wait_idle(n); check("R10 program in suspend", 16'(n), 16'(PROG));
        exp_mem[12'h720] = 16'hABCD;
        rd(12'h720, q); check("R10 program data", q, 16'hABCD);
        w0 = wr_seen;
        std_prog(12'h630, 16'h1111);
        check("R10 erase sector prog dropped", {12'd0, bank_busy}, 16'h0000);
        @(negedge clk); check("R10 no write", 16'(wr_seen - w0), 16'h0000);
        wr(12'h000, 16'h0030);
        check("R13 resumed bank", {12'd0, bank_busy}, 16'h0002);
        wait_idle(n);
        check("R10 resumed mask", er_mask, 16'h0040);
        apply_erase(16'h0040);
        rd(12'h610, q); check("R10 erased", q, 16'hFFFF);

        // random programs, mixed standard and accelerated forms
        for (int it = 0; it < 24; it++) begin
            logic [11:0] a, o;
            logic [15:0] d;
            int s;
            s = $urandom_range(0, 13); if (s >= 8) s++;
            a = {4'(s), 8'($urandom_range(0, 255))};
            d = 16'($urandom);
            o = {a[11:10] + 2'd1, 10'($urandom_range(0, 1023))};
            if ($urandom_range(0, 1) == 1) begin
                accel = 1; wr(12'h000, 16'h00A0); wr(a, d);
            end else std_prog(a, d);
            check("R13 random busy", {12'd0, bank_busy}, {12'd0, bank_bit(a)});
            rd(o, q); check("R6 random other bank", q, exp_mem[o]);
            wait_idle(n); accel = 0;
            exp_mem[a] = d;
            rd(a, q); check("R2 random data", q, d);
        end

        // R9 chip erase
        ers_pre(); wr(12'h555, 16'h0010);
        check("R13 chip busy", {12'd0, bank_busy}, 16'h000F);
        wait_idle(n);
        check("R9 mask", er_mask, 16'h7EFF);
        apply_erase(16'h7EFF);
        rd(12'h0A0, q); check("R9 erased", q, 16'hFFFF);
        rd(12'hF10, q); check("R9 protected kept", q, exp_mem[12'hF10]);

        summary();
    end

endmodule